// File: doc/BRIEF.md
# Card Clock Divider with Glitch-Free Reprogramming

This block derives the clock for a memory-card bus from a faster source clock. A single configuration word selects one of three behaviours. The source can be forwarded unchanged. It can be halved. It can be divided by four times a 12-bit divisor. Software writes the word whenever the bus speed must change, for example when it moves from the slow identification rate to full speed. It then polls a stable flag before it issues the next card command.

A write does not alter the output straight away. The block holds the new setting as pending and commits it only at a point where the card clock is about to go low. The output therefore never shows a shortened high or low phase. After each commit the stable flag stays low until the output has completed two whole periods at the new rate. A write that repeats the setting already requested leaves everything untouched.

Top module: `sdclk_divider`

## Requirements
- R1: When the mode field equals 1, the card clock follows the source clock: high while the source is high and low while it is low.
- R2: When the mode field is any value other than 1 and the divisor is 0, the card clock has a period of 2 source cycles, high for 1 cycle and low for 1 cycle.
- R3: When the mode field is not 1 and the divisor is N ≥ 1, the card clock has a period of 4·N source cycles, high for 2·N cycles and low for 2·N cycles.
- R4: The divisor is taken from cfg_wdata[19:8] and the mode from cfg_wdata[21:20]. All other bits of cfg_wdata have no effect.
- R5: A write whose mode or divisor differs from the most recently requested setting drives clk_stable low at the next rising source edge. A write equal to that setting changes neither the output nor clk_stable.
- R6: A pending setting is committed only at a source rising edge where the output is about to fall. In a divided mode this is the edge that ends a high phase. In pass-through mode it is any edge, and the output falls half a cycle later. A divided output starts low after the commit.
- R7: After a commit, clk_stable rises at the edge that completes the second full output period. In a divided mode that is the second high-to-low edge of the divided output. In pass-through mode it is the second source edge. clk_stable is low whenever a setting is pending.
- R8: A synchronous active-high reset selects mode 0 with divisor 0, drives the output low and clk_stable low, and lets clk_stable rise after the first complete output period (the second source edge after reset is released).
- R9: A second differing write that arrives while a setting is pending replaces it. Only the latest setting is ever committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 32 | Configuration word holding the mode and divisor fields |
| card_clk | output | 1 | Generated card clock |
| clk_stable | output | 1 | High once the requested setting is in effect and settled |

## Verification
The bench builds the block with its default field widths and positions: a 12-bit divisor at bit 8 and a 2-bit mode at bit 20. This covers the largest divisor, 4095, whose half period of 8190 cycles exercises the full width of the counter. The bench also sets bits outside both fields, so R4 is tested with the real word layout. Divisors 1, 3 and 5 are used, along with the halving mode selected through two different mode codes. Pass-through is entered and left while the divided clock is running. A reset is applied in the middle of a running setting.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int DIV_W  = 12;
    localparam int MODE_W = 2;
    localparam int CNT_W  = DIV_W + 1;
    localparam int PER_W  = 2;

    localparam logic [MODE_W-1:0] MODE_PASS = MODE_W'(1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DIV_W-1:0]  div;
    } clk_sel_t;

    localparam clk_sel_t SEL_RESET = '{mode: '0, div: '0};

    function automatic logic is_pass(clk_sel_t s);
        return s.mode == MODE_PASS;
    endfunction

    // source cycles per output half period in a divided mode
    function automatic logic [CNT_W-1:0] half_len(clk_sel_t s);
        if (s.div == '0)
            return CNT_W'(1);
        return {s.div, 1'b0};
    endfunction

endpackage

// File: rtl/sdclk_cfg_track.sv
module sdclk_cfg_track
    import sdclk_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int DIV_LSB  = 8,
    parameter int MODE_LSB = DIV_LSB + DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  clk_sel_t         act,
    input  logic             apply,
    output clk_sel_t         pend,
    output logic             pend_valid,
    output logic             chg
);

    clk_sel_t wr_sel;
    clk_sel_t req_sel;

    always_comb begin
        wr_sel.mode = wdata[MODE_LSB +: MODE_W];
        wr_sel.div  = wdata[DIV_LSB +: DIV_W];
        req_sel     = pend_valid ? pend : act;
        chg         = we && (wr_sel != req_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend       <= SEL_RESET;
            pend_valid <= 1'b0;
        end else if (chg) begin
            pend       <= wr_sel;
            pend_valid <= 1'b1;
        end else if (apply) begin
            pend_valid <= 1'b0;
        end
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_valid && !chg && !apply) |=> $stable(pend));

    // R5
    chg_pend_chk: assert property (@(posedge clk) disable iff (rst)
        chg |=> pend_valid);

endmodule

// File: rtl/sdclk_div_core.sv
module sdclk_div_core
    import sdclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_t pend,
    input  logic     pend_valid,
    output clk_sel_t act,
    output logic     div_q,
    output logic     apply,
    output logic     period_end
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half;
    logic             pass;
    logic             last;
    logic             fall_pt;

    always_comb begin
        half       = half_len(act);
        pass       = is_pass(act);
        last       = (cnt_q == half - CNT_W'(1));
        fall_pt    = pass || (div_q && last);
        apply      = pend_valid && fall_pt;
        period_end = fall_pt && !apply;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act   <= SEL_RESET;
            div_q <= 1'b0;
            cnt_q <= '0;
        end else if (apply) begin
            act   <= pend;
            div_q <= 1'b0;
            cnt_q <= '0;
        end else if (pass) begin
            div_q <= 1'b0;
            cnt_q <= '0;
        end else if (last) begin
            div_q <= ~div_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R6
    apply_low_chk: assert property (@(posedge clk) disable iff (rst)
        apply |=> (!div_q && cnt_q == '0));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        !pass |-> (cnt_q < half));

endmodule

// File: rtl/sdclk_stable_mon.sv
module sdclk_stable_mon
    import sdclk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic apply,
    input  logic period_end,
    input  logic chg,
    input  logic pend_valid,
    output logic stable
);

    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] per_n;
    logic             pend_n;

    always_comb begin
        pend_n = chg || (pend_valid && !apply);
        if (apply)
            per_n = '0;
        else if (period_end && per_q != PER_W'(2))
            per_n = per_q + PER_W'(1);
        else
            per_n = per_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q  <= PER_W'(1);
            stable <= 1'b0;
        end else begin
            per_q  <= per_n;
            stable <= !pend_n && (per_n == PER_W'(2));
        end
    end

    // R7
    stable_pend_chk: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> !stable);

    // R7
    stable_apply_chk: assert property (@(posedge clk) disable iff (rst)
        apply |=> !stable);

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int DIV_LSB  = 8,
    parameter int MODE_LSB = DIV_LSB + DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             card_clk,
    output logic             clk_stable
);

    clk_sel_t act;
    clk_sel_t pend;
    logic     pend_valid;
    logic     chg;
    logic     apply;
    logic     period_end;
    logic     div_q;
    logic     pass_sel;

    sdclk_cfg_track #(
        .CFG_W   (CFG_W),
        .DIV_LSB (DIV_LSB),
        .MODE_LSB(MODE_LSB)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .act       (act),
        .apply     (apply),
        .pend      (pend),
        .pend_valid(pend_valid),
        .chg       (chg)
    );

    sdclk_div_core u_core (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .pend_valid(pend_valid),
        .act       (act),
        .div_q     (div_q),
        .apply     (apply),
        .period_end(period_end)
    );

    sdclk_stable_mon u_stable (
        .clk       (clk),
        .rst       (rst),
        .apply     (apply),
        .period_end(period_end),
        .chg       (chg),
        .pend_valid(pend_valid),
        .stable    (clk_stable)
    );

    // output select changes only while the source is low and div_q is low
    always_ff @(negedge clk) begin
        if (rst)
            pass_sel <= 1'b0;
        else
            pass_sel <= is_pass(act);
    end

    assign card_clk = pass_sel ? clk : div_q;

    // R8
    rst_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !clk_stable);

endmodule

// File: tb/sdclk_divider_test.sv
module sdclk_divider_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        card_clk;
    logic        clk_stable;

    int n_chk = 0;
    int n_bad = 0;
    string note = "";

    // reference model state
    int  am = 0, ad = 0, pm = 0, pd = 0;
    bit  pv = 0;
    int  j = 0, per = 1;
    bit  m_dq = 0, m_stb = 0, m_sel = 0, m_sel_hi = 0;

    always #(PERIOD/2) clk = ~clk;

    sdclk_divider uut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .card_clk  (card_clk),
        .clk_stable(clk_stable)
    );

    function automatic logic [31:0] word(int mode, int div, logic [31:0] junk);
        logic [31:0] w;
        w = junk & ~32'h003F_FF00;
        w[21:20] = mode[1:0];
        w[19:8]  = div[11:0];
        return w;
    endfunction

    function automatic string mode_tag();
        if (am == 1) return "R1";
        if (ad == 0) return "R2";
        return "R3";
    endfunction

    task automatic check(string req, logic act_v, logic exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, note, act_v, exp_v, $time);
        end
    endtask

    task automatic model_edge(logic we, logic [31:0] wd);
        int  h, nm, nd, rm, rd;
        bit  byp, fall_pt, apply, chg;
        m_sel_hi = m_sel;
        if (rst) begin
            am = 0; ad = 0; pm = 0; pd = 0; pv = 0;
            j = 0; per = 1; m_dq = 0; m_stb = 0;
        end else begin
            byp = (am == 1);
            h = (ad == 0) ? 1 : 2 * ad;
            fall_pt = byp || (m_dq && ((j + 1) % h == 0));
            apply = pv && fall_pt;
            nm = int'(wd[21:20]);
            nd = int'(wd[19:8]);
            rm = pv ? pm : am;
            rd = pv ? pd : ad;
            chg = we && (nm != rm || nd != rd);
            if (apply) begin
                am = pm; ad = pd; j = 0; per = 0;
            end else begin
                if (fall_pt && per < 2) per++;
                if (!byp) j++;
            end
            h = (ad == 0) ? 1 : 2 * ad;
            m_dq = (am == 1) ? 1'b0 : (((j / h) % 2) == 1);
            if (chg) begin
                pm = nm; pd = nd; pv = 1;
            end else if (apply) begin
                pv = 0;
            end
            m_stb = !pv && per >= 2;
        end
        m_sel = rst ? 1'b0 : (am == 1);
    endtask

    task automatic step(logic we, logic [31:0] wd);
        cfg_we = we;
        cfg_wdata = wd;
        @(posedge clk);
        model_edge(we, wd);
        #2;
        check({mode_tag(), " R6 high phase"}, card_clk, m_sel_hi ? 1'b1 : m_dq);
        check("R7 stable", clk_stable, m_stb);
        #5;
        check({mode_tag(), " R6 low phase"}, card_clk, m_sel ? 1'b0 : m_dq);
        cfg_we = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(1'b0, '0);
    endtask

    initial begin
        note = "R8 reset";
        rst = 1'b1;
        run(3);
        check("R8 stable low in reset", clk_stable, 1'b0);
        rst = 1'b0;
        run(12);
        note = "R3 divisor 1";
        step(1'b1, word(0, 1, '0));
        run(30);
        note = "R5 same value";
        step(1'b1, word(0, 1, '0));
        check("R5 stable kept", clk_stable, 1'b1);
        run(8);
        note = "R1 pass-through";
        step(1'b1, word(1, 0, '0));
        run(12);
        note = "R4 junk bits";
        step(1'b1, word(0, 3, 32'hFFC0_00FF));
        run(60);
        step(1'b1, word(0, 3, 32'h5A00_0055));
        check("R4 stable kept", clk_stable, 1'b1);
        run(4);
        note = "R9 overwrite";
        step(1'b1, word(0, 5, '0));
        step(1'b1, word(0, 2, '0));
        run(50);
        note = "R2 mode 2";
        step(1'b1, word(2, 0, '0));
        run(12);
        note = "R1 from halving";
        step(1'b1, word(1, 0, '0));
        run(6);
        note = "R3 max divisor";
        step(1'b1, word(0, 4095, '0));
        run(4 * 8190 + 40);
        note = "R6 back to pass";
        step(1'b1, word(1, 0, '0));
        run(8200);
        note = "R8 reset mid-run";
        step(1'b1, word(0, 3, '0));
        run(20);
        rst = 1'b1;
        run(2);
        rst = 1'b0;
        run(20);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule